// File: doc/BRIEF.md
# Memory-to-Stream Word DMA Read Channel

This block is a single-channel engine that fetches 32-bit words from a word-addressed memory port and emits them, one beat at a time, on a valid/ready stream output. Software programs a start address, an optional control word and then a byte count. The write of the byte count is the go signal: from then on the channel issues one read at a time, waits for the response, presents the word on the stream and waits for it to be accepted before fetching the next one.

Per-word options: the source address either steps by four bytes per accepted word or stays fixed (for draining a data port), the four bytes of each word can be reversed on their way to the stream, and every good word, taken as read and before any reversal, is added into a wrapping 32-bit checksum register. Bit 0 of the count write is a separate end-of-packet flag; when set, the last word carries the stream's last marker. Completion, zero-length starts and read errors are posted in a small write-one-to-clear interrupt status register whose OR drives the interrupt output.

Register indices on `cfg_addr`: 0 start/current address, 1 byte count (write starts), 2 control (bit 0 and bit 1 are the two pause bits, bit 2 fixed address, bit 3 byte reversal), 3 checksum, 4 interrupt status (bit 0 memory-done, bit 1 done, bit 2 read error; write 1 to clear), 5 status (bit 0 busy). Other indices read as zero.

Top module: `strm_rd_dma`

## Requirements
- R1: The low two bits of written address (index 0) and count (index 1) are stored as zero; reading index 1 returns the remaining count with the stored last-word flag (bit 0 of the count write) ORed into bit 0.
- R2: Writing a nonzero count sets busy (index 5 bit 0); reads are issued only while busy, with at most one read outstanding and never while a word waits on the stream.
- R3: Writing a count of zero leaves busy low and sets both done (bit 1) and memory-done (bit 0) of the interrupt status on the next clock edge.
- R4: With control bit 2 clear the address rises by 4 per accepted word; with it set every read uses the start address and the address register keeps it; in both modes the count drops by 4 per accepted word.
- R5: The last marker is raised only with the final word of a transfer and only when the last-word flag was written as 1.
- R6: Each word read without error is added, modulo 2^32, into the checksum (index 3) in the form delivered by memory, before any byte reversal; software may overwrite the checksum.
- R7: With control bit 3 set the output word is the read word with byte 0 and byte 3 swapped and byte 1 and byte 2 swapped; with it clear the word passes unchanged.
- R8: While control bit 0 or bit 1 is set no new read is issued and busy stays set; clearing both resumes and finishes the transfer.
- R9: A read response flagged as error sets interrupt status bit 2; the word is still delivered and counted, but not added to the checksum.
- R10: A presented word holds its data and marker until accepted; no word is dropped or repeated under back-pressure.
- R11: On acceptance of the final word busy clears and done plus memory-done are set on the same edge; the interrupt output is the OR of the status bits, and writing ones to index 4 clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index for reads and writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | ADDR_W | Byte address of the read, word aligned |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_rerr | input | 1 | Read response error flag |
| m_tvalid | output | 1 | Stream word valid |
| m_tready | input | 1 | Stream word accepted when high with valid |
| m_tdata | output | 32 | Stream word |
| m_tlast | output | 1 | Final word of the packet |
| irq | output | 1 | OR of the interrupt status bits |

## Verification
The hardest state to reach from the ports is a started transfer that sits idle with busy high because a pause bit is set, and then proving that nothing leaks out: the bench programs a pause bit before writing the count, counts memory requests and stream beats over a long window under each pause bit in turn, and only then clears the pause to see the held transfer complete. A read error mid-transfer is produced by a memory model that flags one chosen address, so the checksum must skip exactly that word while the stream still carries it. Back-pressure is a fixed irregular ready pattern that stalls words across several cycles.

// File: rtl/srd_pkg.sv
package srd_pkg;
   localparam int WORD_BYTES = 4;
   localparam int REG_IDX_W  = 3;

   localparam logic [REG_IDX_W-1:0] RIDX_ADDR  = 3'd0;
   localparam logic [REG_IDX_W-1:0] RIDX_COUNT = 3'd1;
   localparam logic [REG_IDX_W-1:0] RIDX_CTRL  = 3'd2;
   localparam logic [REG_IDX_W-1:0] RIDX_CSUM  = 3'd3;
   localparam logic [REG_IDX_W-1:0] RIDX_IRQ   = 3'd4;
   localparam logic [REG_IDX_W-1:0] RIDX_STAT  = 3'd5;

   localparam int CTL_W         = 4;
   localparam int CTL_HOLD_A    = 0;
   localparam int CTL_HOLD_B    = 1;
   localparam int CTL_FIXED     = 2;
   localparam int CTL_REVERSE   = 3;

   localparam int IRQ_W         = 3;
   localparam int IRQ_MEMDONE   = 0;
   localparam int IRQ_DONE      = 1;
   localparam int IRQ_RDERR     = 2;

   typedef enum logic [1:0] {
      SRD_IDLE = 2'd0,
      SRD_WAIT = 2'd1,
      SRD_PUSH = 2'd2
   } srd_state_e;
endpackage

// File: rtl/srd_swap.sv
module srd_swap #(
   parameter int LANES   = 4,
   parameter bit SWAP_EN = 1'b1
) (
   input  logic [8*LANES-1:0] din,
   input  logic               reverse,
   output logic [8*LANES-1:0] dout
);
   generate
      if (SWAP_EN) begin : g_rev
         logic [8*LANES-1:0] flipped;
         for (genvar b = 0; b < LANES; b++) begin : g_lane
            assign flipped[8*b +: 8] = din[8*(LANES-1-b) +: 8];
         end
         assign dout = reverse ? flipped : din;
      end else begin : g_pass
         logic unused_rev;
         assign unused_rev = reverse;
         assign dout = din;
      end
   endgenerate
endmodule

// File: rtl/srd_regs.sv
module srd_regs
   import srd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl,
   input  logic             wr_csum,
   input  logic             wr_irq,
   input  logic [31:0]      wdata,
   input  logic             sum_evt,
   input  logic [31:0]      sum_word,
   input  logic             done_evt,
   input  logic             err_evt,
   output logic [CTL_W-1:0] ctrl_q,
   output logic [31:0]      csum_q,
   output logic [IRQ_W-1:0] irq_q
);
   logic [IRQ_W-1:0] irq_set, irq_clr;

   always_comb begin
      irq_set = '0;
      irq_set[IRQ_MEMDONE] = done_evt;
      irq_set[IRQ_DONE]    = done_evt;
      irq_set[IRQ_RDERR]   = err_evt;
      irq_clr = wr_irq ? wdata[IRQ_W-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         csum_q <= '0;
         irq_q  <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= wdata[CTL_W-1:0];
         if (wr_csum)      csum_q <= wdata;
         else if (sum_evt) csum_q <= csum_q + sum_word;
         // new events win over a simultaneous clear
         irq_q <= (irq_q & ~irq_clr) | irq_set;
      end
   end
endmodule

// File: rtl/srd_engine.sv
module srd_engine
   import srd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_addr,
   input  logic              ld_cnt,
   input  logic [31:0]       wdata,
   input  logic              paused,
   input  logic              fixed_mode,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_word,
   input  logic              mem_rerr,
   output logic              tvalid,
   output logic [31:0]       tdata,
   output logic              tlast,
   input  logic              tready,
   output logic [ADDR_W-1:0] addr_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              last_q,
   output logic              busy_q,
   output logic              done_evt,
   output logic              err_evt,
   output logic              sum_evt
);
   localparam logic [CNT_W-1:0]  CNT_STEP  = CNT_W'(WORD_BYTES);
   localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_BYTES);
   localparam logic [CNT_W-1:0]  CNT_MASK  = ~CNT_W'(WORD_BYTES - 1);
   localparam logic [ADDR_W-1:0] ADDR_MASK = ~ADDR_W'(WORD_BYTES - 1);

   srd_state_e       state;
   logic [31:0]      hold_q;
   logic [CNT_W-1:0] cnt_load;
   logic             beat_ok, final_word, resp_ok;

   always_comb begin
      cnt_load   = wdata[CNT_W-1:0] & CNT_MASK;
      beat_ok    = (state == SRD_PUSH) && tready;
      final_word = (cnt_q == CNT_STEP);
      resp_ok    = (state == SRD_WAIT) && mem_rvalid && !ld_cnt;
      mem_req    = (state == SRD_IDLE) && busy_q && !paused && !ld_cnt;
      mem_addr   = addr_q;
      tvalid     = (state == SRD_PUSH);
      tdata      = hold_q;
      tlast      = tvalid && last_q && final_word;
      done_evt   = (ld_cnt && (cnt_load == '0)) || (beat_ok && final_word && !ld_cnt);
      err_evt    = resp_ok && mem_rerr;
      sum_evt    = resp_ok && !mem_rerr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SRD_IDLE;
         addr_q <= '0;
         cnt_q  <= '0;
         last_q <= 1'b0;
         busy_q <= 1'b0;
         hold_q <= '0;
      end else begin
         if (ld_addr) addr_q <= wdata[ADDR_W-1:0] & ADDR_MASK;
         else if (beat_ok && !fixed_mode && !ld_cnt) addr_q <= addr_q + ADDR_STEP;

         if (ld_cnt) begin
            cnt_q  <= cnt_load;
            last_q <= wdata[0];
            busy_q <= (cnt_load != '0);
            state  <= SRD_IDLE;
         end else begin
            unique case (state)
               SRD_IDLE: if (mem_req) state <= SRD_WAIT;
               SRD_WAIT: if (mem_rvalid) begin
                  hold_q <= mem_word;
                  state  <= SRD_PUSH;
               end
               SRD_PUSH: if (tready) begin
                  cnt_q <= cnt_q - CNT_STEP;
                  state <= SRD_IDLE;
                  if (final_word) busy_q <= 1'b0;
               end
               default: state <= SRD_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/strm_rd_dma.sv
module strm_rd_dma
   import srd_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int CNT_W   = 20,
   parameter bit SWAP_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [REG_IDX_W-1:0] cfg_addr,
   input  logic [31:0]          cfg_wdata,
   output logic [31:0]          cfg_rdata,
   output logic                 mem_req,
   output logic [ADDR_W-1:0]    mem_addr,
   input  logic                 mem_rvalid,
   input  logic [31:0]          mem_rdata,
   input  logic                 mem_rerr,
   output logic                 m_tvalid,
   input  logic                 m_tready,
   output logic [31:0]          m_tdata,
   output logic                 m_tlast,
   output logic                 irq
);
   generate
      if (ADDR_W < 3 || ADDR_W > 32) begin : g_bad_addr_w
         $error("strm_rd_dma: ADDR_W must lie in 3..32");
      end
      if (CNT_W < 3 || CNT_W > 32) begin : g_bad_cnt_w
         $error("strm_rd_dma: CNT_W must lie in 3..32");
      end
   endgenerate

   logic [CTL_W-1:0]  ctrl_w;
   logic [31:0]       csum_w, swapped_w;
   logic [IRQ_W-1:0]  irq_w;
   logic [ADDR_W-1:0] addr_w;
   logic [CNT_W-1:0]  cnt_w;
   logic              last_w, busy_w, paused_w;
   logic              done_w, err_w, sum_w;
   logic              wr_addr, wr_cnt, wr_ctrl, wr_csum, wr_irq;

   always_comb begin
      wr_addr  = cfg_we && (cfg_addr == RIDX_ADDR);
      wr_cnt   = cfg_we && (cfg_addr == RIDX_COUNT);
      wr_ctrl  = cfg_we && (cfg_addr == RIDX_CTRL);
      wr_csum  = cfg_we && (cfg_addr == RIDX_CSUM);
      wr_irq   = cfg_we && (cfg_addr == RIDX_IRQ);
      paused_w = ctrl_w[CTL_HOLD_A] || ctrl_w[CTL_HOLD_B];
      irq      = |irq_w;
   end

   srd_swap #(.LANES(WORD_BYTES), .SWAP_EN(SWAP_EN)) u_swap (
      .din     (mem_rdata),
      .reverse (ctrl_w[CTL_REVERSE]),
      .dout    (swapped_w)
   );

   srd_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_addr    (wr_addr),
      .ld_cnt     (wr_cnt),
      .wdata      (cfg_wdata),
      .paused     (paused_w),
      .fixed_mode (ctrl_w[CTL_FIXED]),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_word   (swapped_w),
      .mem_rerr   (mem_rerr),
      .tvalid     (m_tvalid),
      .tdata      (m_tdata),
      .tlast      (m_tlast),
      .tready     (m_tready),
      .addr_q     (addr_w),
      .cnt_q      (cnt_w),
      .last_q     (last_w),
      .busy_q     (busy_w),
      .done_evt   (done_w),
      .err_evt    (err_w),
      .sum_evt    (sum_w)
   );

   srd_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (wr_ctrl),
      .wr_csum  (wr_csum),
      .wr_irq   (wr_irq),
      .wdata    (cfg_wdata),
      .sum_evt  (sum_w),
      .sum_word (mem_rdata),
      .done_evt (done_w),
      .err_evt  (err_w),
      .ctrl_q   (ctrl_w),
      .csum_q   (csum_w),
      .irq_q    (irq_w)
   );

   always_comb begin
      unique case (cfg_addr)
         RIDX_ADDR:  cfg_rdata = 32'(addr_w);
         RIDX_COUNT: cfg_rdata = 32'(cnt_w) | 32'(last_w);
         RIDX_CTRL:  cfg_rdata = 32'(ctrl_w);
         RIDX_CSUM:  cfg_rdata = csum_w;
         RIDX_IRQ:   cfg_rdata = 32'(irq_w);
         RIDX_STAT:  cfg_rdata = 32'(busy_w);
         default:    cfg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/srd_dma_chk.sv
module srd_dma_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              tvalid,
   input logic              tready,
   input logic [31:0]       tdata,
   input logic              tlast,
   input logic [2:0]        irq_bits
);
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tvalid && !tready) |=> (tvalid && $stable(tdata) && $stable(tlast)));

   assert_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tlast |-> tvalid);

   assert_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   assert_one_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (!tvalid && busy));

   assert_no_b2b_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   assert_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (irq_bits[1] && irq_bits[0]));
endmodule

bind strm_rd_dma srd_dma_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy_w),
   .mem_req  (mem_req),
   .mem_addr (mem_addr),
   .tvalid   (m_tvalid),
   .tready   (m_tready),
   .tdata    (m_tdata),
   .tlast    (m_tlast),
   .irq_bits (irq_w)
);

// File: tb/strm_rd_dma_tb_top.sv
module strm_rd_dma_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = 3'd0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid;
   logic [31:0] mem_rdata;
   logic        mem_rerr;
   logic        m_tvalid, m_tlast, irq;
   logic        m_tready;
   logic [31:0] m_tdata;

   int unsigned n_chk = 0, n_fail = 0;
   logic [31:0] err_addr = 32'hFFFF_FFF0;
   logic        bp_mode = 1'b0;

   always #5 clk = ~clk;

   strm_rd_dma dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .mem_rerr(mem_rerr), .m_tvalid(m_tvalid), .m_tready(m_tready),
      .m_tdata(m_tdata), .m_tlast(m_tlast), .irq(irq)
   );

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return {a[15:0] ^ 16'h5A3C, a[15:0] + 16'h0F1E};
   endfunction

   function automatic logic [31:0] rev32(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   // memory model: one cycle after a request, respond
   logic        pend;
   logic [31:0] paddr;
   int unsigned req_cnt;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0; paddr <= '0; mem_rvalid <= 1'b0;
         mem_rdata <= '0; mem_rerr <= 1'b0; req_cnt <= 0;
      end else begin
         mem_rvalid <= 1'b0;
         mem_rerr   <= 1'b0;
         if (mem_req) begin
            pend <= 1'b1; paddr <= mem_addr; req_cnt <= req_cnt + 1;
         end
         if (pend) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem_word(paddr);
            mem_rerr   <= (paddr == err_addr);
            pend       <= 1'b0;
         end
      end
   end

   // stream sink ready pattern, changed away from the active edge
   logic [2:0] tick = '0;
   always @(negedge clk) begin
      tick     <= tick + 3'd1;
      m_tready <= !bp_mode || (tick == 3'd2) || (tick == 3'd5);
   end

   // beat capture
   logic [31:0] cap_data [256];
   logic        cap_last [256];
   logic [7:0]  cap_n;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_n <= '0;
      else if (m_tvalid && m_tready) begin
         cap_data[cap_n] <= m_tdata;
         cap_last[cap_n] <= m_tlast;
         cap_n <= cap_n + 8'd1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      cfg_addr = a;
      #1 v = cfg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 2000; i++) begin
         rd(3'd5, v);
         if (!v[0]) break;
      end
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int r = 0; r < 6; r++) begin
         rd(3'(r), v);
         chk("R2 reset register", v, 32'd0);
      end
      chk("R11 reset irq", {31'd0, irq}, 32'd0);
      chk("R10 reset tvalid", {31'd0, m_tvalid}, 32'd0);
   endtask

   task automatic t_align_zero();
      logic [31:0] v;
      wr(3'd2, 32'h3);
      wr(3'd0, 32'h0000_0103);
      rd(3'd0, v); chk("R1 address low bits", v, 32'h0000_0100);
      wr(3'd1, 32'h13);
      rd(3'd1, v); chk("R1 count readback with flag", v, 32'h11);
      rd(3'd5, v); chk("R2 busy after start", v, 32'd1);
      wr(3'd1, 32'h0);
      rd(3'd5, v); chk("R3 zero count busy", v, 32'd0);
      rd(3'd4, v); chk("R3 zero count irq bits", v, 32'h3);
      chk("R11 irq output", {31'd0, irq}, 32'd1);
      wr(3'd4, 32'h7);
      rd(3'd4, v); chk("R11 w1c clear", v, 32'd0);
      chk("R11 irq output cleared", {31'd0, irq}, 32'd0);
      wr(3'd2, 32'h0);
   endtask

   task automatic t_incr();
      logic [31:0] v, sum;
      logic [7:0]  base;
      base = cap_n; sum = 0;
      wr(3'd3, 32'h0);
      wr(3'd0, 32'hFFFF_FF00);
      wr(3'd1, 32'h11);
      wait_idle();
      chk("R4 beat count incr", 32'(cap_n - base), 32'd4);
      for (int i = 0; i < 4; i++) begin
         chk("R4 incr data", cap_data[8'(base + i)], mem_word(32'hFFFF_FF00 + 32'(4*i)));
         chk("R5 last only on final", {31'd0, cap_last[8'(base + i)]}, {31'd0, i == 3});
         sum += mem_word(32'hFFFF_FF00 + 32'(4*i));
      end
      rd(3'd0, v); chk("R4 address advanced", v, 32'hFFFF_FF10);
      rd(3'd1, v); chk("R4 count drained, flag kept", v, 32'h1);
      rd(3'd3, v); chk("R6 checksum incr", v, sum);
      rd(3'd4, v); chk("R11 done bits", v, 32'h3);
      wr(3'd4, 32'h7);
   endtask

   task automatic t_fixed_swap();
      logic [31:0] v;
      logic [7:0]  base;
      base = cap_n;
      wr(3'd3, 32'h0);
      wr(3'd2, 32'hC);
      wr(3'd0, 32'h300);
      wr(3'd1, 32'hC);
      wait_idle();
      chk("R4 beat count fixed", 32'(cap_n - base), 32'd3);
      for (int i = 0; i < 3; i++) begin
         chk("R7 reversed data", cap_data[8'(base + i)], rev32(mem_word(32'h300)));
         chk("R5 no last without flag", {31'd0, cap_last[8'(base + i)]}, 32'd0);
      end
      rd(3'd0, v); chk("R4 fixed address kept", v, 32'h300);
      rd(3'd3, v); chk("R6 checksum before reversal", v, mem_word(32'h300) * 32'd3);
      wr(3'd2, 32'h0);
      wr(3'd4, 32'h7);
   endtask

   task automatic t_backpressure();
      logic [7:0] base;
      base = cap_n;
      bp_mode = 1'b1;
      wr(3'd0, 32'h400);
      wr(3'd1, 32'h19);
      wait_idle();
      bp_mode = 1'b0;
      chk("R10 no beat lost", 32'(cap_n - base), 32'd6);
      for (int i = 0; i < 6; i++) begin
         chk("R10 order under stall", cap_data[8'(base + i)], mem_word(32'h400 + 32'(4*i)));
         chk("R5 last under stall", {31'd0, cap_last[8'(base + i)]}, {31'd0, i == 5});
      end
      wr(3'd4, 32'h7);
   endtask

   task automatic t_pause();
      logic [31:0] v;
      logic [7:0]  base;
      int unsigned r0;
      base = cap_n;
      wr(3'd2, 32'h1);
      r0 = req_cnt;
      wr(3'd0, 32'h500);
      wr(3'd1, 32'h8);
      repeat (30) @(negedge clk);
      chk("R8 no read under first pause", req_cnt - r0, 0);
      wr(3'd2, 32'h2);
      repeat (30) @(negedge clk);
      chk("R8 no read under second pause", req_cnt - r0, 0);
      chk("R8 no beats paused", 32'(cap_n - base), 32'd0);
      rd(3'd5, v); chk("R8 busy while paused", v, 32'd1);
      wr(3'd2, 32'h0);
      wait_idle();
      chk("R8 resumed beats", 32'(cap_n - base), 32'd2);
      chk("R8 resumed data", cap_data[8'(base + 1)], mem_word(32'h504));
      wr(3'd4, 32'h7);
   endtask

   task automatic t_error();
      logic [31:0] v;
      logic [7:0]  base;
      base = cap_n;
      err_addr = 32'h604;
      wr(3'd3, 32'h0);
      wr(3'd0, 32'h600);
      wr(3'd1, 32'hC);
      wait_idle();
      err_addr = 32'hFFFF_FFF0;
      chk("R9 errored word still delivered", 32'(cap_n - base), 32'd3);
      chk("R9 errored data", cap_data[8'(base + 1)], mem_word(32'h604));
      rd(3'd4, v); chk("R9 error status bit", v, 32'h7);
      rd(3'd3, v); chk("R6 checksum skips errored word", v, mem_word(32'h600) + mem_word(32'h608));
      rd(3'd1, v); chk("R9 count fully drained", v, 32'h0);
      wr(3'd4, 32'h7);
   endtask

   initial begin
      logic timed_out;
      timed_out = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      fork
         begin
            t_reset();
            t_align_zero();
            t_incr();
            t_fixed_swap();
            t_backpressure();
            t_pause();
            t_error();
         end
         begin
            repeat (100000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule